// File: doc/BRIEF.md
# Reference Clock Loss Supervisor

This block runs on a free-running local oscillator clock and watches a reference clock that has already been synchronized into that domain. It measures the spacing of rising reference edges in local cycles and keeps a lock status. From that status it drives an enable that gates the synthesized output clock. Analog loop behaviour is represented by a parameterized settling count.

The block treats the loss of the reference in three ways. If the reference stops cleanly, the lock is held through a long timeout before it is dropped. If the reference comes back before that timeout, the block goes through a lock-settling period. If the reference changes its period abruptly, the block unlocks at once. A skip-enable input matters only when the reference returns after a very short gap: it then keeps the output running through re-acquisition. An unlocked-output input selects whether the output keeps toggling or is held off whenever the block is not locked.

The timeout, the short-gap threshold, the settling time and the period tolerance are all parameters. A bench can therefore use small values in place of the multi-million-cycle timeout used in silicon.

Top module: `ref_loss_supervisor`

## Requirements
- R1: During and right after reset, `locked` is 0 and the block waits for the reference.
- R2: Lock is reached only after two consecutive period measurements agree within tolerance. `locked` then rises LOCK_CYC+1 cycles after the edge that completes the second matching measurement, and not before.
- R3: While `locked` is 1, `out_en` is 1 whatever `skip_en` and `out_unl` are.
- R4: If the reference stops cleanly while locked, `locked` and `out_en` stay 1 until TIMEOUT_CYC cycles have passed since the last rising edge. After that, `locked` falls.
- R5: While unlocked and not in a skip hold, `out_en` equals `out_unl`: 0 gates the output off, 1 lets it run.
- R6: While locked, a rising edge whose measured period differs from the previous period by more than previous>>TOL_SHIFT unlocks the block on the next cycle, without waiting for the timeout.
- R7: A period change of at most previous>>TOL_SHIFT (2 cycles for a 16-cycle period with TOL_SHIFT=3) keeps the block locked.
- R8: After a timeout unlock, a returning reference has to go through the full acquisition of R2 before `locked` rises again.
- R9: If the reference returns when TCS_CYC or more cycles have passed since its last edge (but before the timeout), the block is unlocked while it settles, and `out_en` follows `out_unl` whatever `skip_en` is.
- R10: If the reference returns when fewer than TCS_CYC cycles have passed since its last edge and `skip_en` is 1, `out_en` stays 1 through re-acquisition even when `out_unl` is 0.
- R11: If the same short return happens with `skip_en` at 0, `out_en` follows `out_unl` during re-acquisition. Lock comes back after the settling time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, already synchronized to `clk` |
| skip_en | input | 1 | Keeps the output running through re-acquisition after a short gap |
| out_unl | input | 1 | 1: the output runs while unlocked; 0: it is gated off |
| locked | output | 1 | Lock status |
| out_en | output | 1 | Enable for the synthesized output clock |

## Verification
The period comparison is driven by a table of single altered periods around a steady 16-cycle reference. The entries fall just inside the tolerance, just outside it, and far outside it, so these cases show exactly where the tolerance boundary lies. Reference stoppages are then applied at three lengths: short of the skip threshold, between that threshold and the timeout, and past the timeout. These cases separate the hold, skip and full-reacquisition paths. Each stoppage is repeated with different settings of `skip_en` and `out_unl`, which shows that the skip bit only matters for the shortest gap.

// File: rtl/ref_sup_pkg.sv
package ref_sup_pkg;

    typedef enum logic [1:0] {
        ST_ACQ    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCK   = 2'd2,
        ST_HOLD   = 2'd3
    } sup_state_e;

    typedef struct packed {
        logic pulse;    // rising reference edge this cycle
        logic valid;    // a previous period is stored
        logic match;    // current measurement agrees with stored one
        logic missing;  // no edge within twice the stored period
        logic stale;    // gap has reached the long timeout
    } meter_flags_t;

    function automatic logic per_close(input logic [31:0] cur,
                                       input logic [31:0] ref_per,
                                       input int unsigned sh);
        logic [31:0] diff;
        diff = (cur > ref_per) ? (cur - ref_per) : (ref_per - cur);
        return diff <= (ref_per >> sh);
    endfunction

endpackage

// File: rtl/ref_period_meter.sv
module ref_period_meter
    import ref_sup_pkg::*;
#(
    parameter int CNT_W       = 25,
    parameter int TOL_SHIFT   = 3,
    parameter int TIMEOUT_CYC = 8388608
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             restart,
    output meter_flags_t     flags,
    output logic [CNT_W-1:0] since
);

    logic             ref_d;
    logic             valid_q;
    logic [CNT_W-1:0] last_per;
    logic [CNT_W-1:0] meas;
    logic             rise;
    logic [CNT_W:0]   since_x;
    logic [CNT_W:0]   twice_per;

    assign rise      = ref_in & ~ref_d;
    assign meas      = (since == '1) ? since : since + 1'b1;
    assign since_x   = {1'b0, since};
    assign twice_per = {last_per, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d    <= 1'b0;
            since    <= '0;
            last_per <= '0;
            valid_q  <= 1'b0;
        end else begin
            ref_d <= ref_in;
            if (rise) begin
                since    <= '0;
                last_per <= meas;
                valid_q  <= ~restart;
            end else if (since != '1) begin
                since <= since + 1'b1;
            end
        end
    end

    always_comb begin
        flags.pulse   = rise;
        flags.valid   = valid_q;
        flags.match   = valid_q && per_close(32'(meas), 32'(last_per), TOL_SHIFT);
        flags.missing = valid_q && (since_x >= twice_per);
        flags.stale   = since >= CNT_W'(TIMEOUT_CYC);
    end

endmodule

// File: rtl/ref_settle_timer.sv
module ref_settle_timer #(
    parameter int LOCK_CYC = 65536,
    parameter int TW       = $clog2(LOCK_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= TW'(LOCK_CYC - 1);
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = run && (remain == '0);

endmodule

// File: rtl/ref_lock_fsm.sv
module ref_lock_fsm
    import ref_sup_pkg::*;
#(
    parameter int CNT_W  = 25,
    parameter int TCS_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  meter_flags_t     flags,
    input  logic [CNT_W-1:0] since,
    input  logic             timer_done,
    input  logic             skip_en,
    output sup_state_e       state,
    output logic             skip_q,
    output logic             timer_load,
    output logic             restart
);

    sup_state_e nxt;
    logic       skip_n;
    logic       short_gap;

    assign short_gap = since < CNT_W'(TCS_CYC);

    always_comb begin
        nxt        = state;
        skip_n     = skip_q;
        timer_load = 1'b0;
        restart    = 1'b0;
        unique case (state)
            ST_ACQ: begin
                if (flags.pulse && flags.match) begin
                    nxt        = ST_SETTLE;
                    timer_load = 1'b1;
                    skip_n     = 1'b0;
                end
            end
            ST_SETTLE: begin
                if ((flags.pulse && flags.valid && !flags.match) ||
                    flags.missing || (!flags.valid && flags.stale)) begin
                    nxt    = ST_ACQ;
                    skip_n = 1'b0;
                end else if (timer_done && flags.valid) begin
                    nxt    = ST_LOCK;
                    skip_n = 1'b0;
                end
            end
            ST_LOCK: begin
                if (flags.pulse && !flags.match) begin
                    nxt = ST_ACQ;
                end else if (flags.missing) begin
                    nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (flags.pulse) begin
                    nxt        = ST_SETTLE;
                    timer_load = 1'b1;
                    restart    = 1'b1;
                    skip_n     = skip_en && short_gap;
                end else if (flags.stale) begin
                    nxt = ST_ACQ;
                end
            end
            default: nxt = ST_ACQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ACQ;
            skip_q <= 1'b0;
        end else begin
            state  <= nxt;
            skip_q <= skip_n;
        end
    end

endmodule

// File: rtl/ref_loss_supervisor.sv
module ref_loss_supervisor
    import ref_sup_pkg::*;
#(
    parameter int TIMEOUT_CYC = 8388608,
    parameter int TCS_CYC     = 4096,
    parameter int LOCK_CYC    = 65536,
    parameter int TOL_SHIFT   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic skip_en,
    input  logic out_unl,
    output logic locked,
    output logic out_en
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1) + 1;

    meter_flags_t     flags;
    logic [CNT_W-1:0] since;
    sup_state_e       state;
    logic             skip_q;
    logic             timer_load;
    logic             timer_done;
    logic             restart;

    ref_period_meter #(
        .CNT_W      (CNT_W),
        .TOL_SHIFT  (TOL_SHIFT),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .restart(restart),
        .flags  (flags),
        .since  (since)
    );

    ref_settle_timer #(
        .LOCK_CYC(LOCK_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .load(timer_load),
        .run (state == ST_SETTLE),
        .done(timer_done)
    );

    ref_lock_fsm #(
        .CNT_W  (CNT_W),
        .TCS_CYC(TCS_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .since     (since),
        .timer_done(timer_done),
        .skip_en   (skip_en),
        .state     (state),
        .skip_q    (skip_q),
        .timer_load(timer_load),
        .restart   (restart)
    );

    assign locked = (state == ST_LOCK) || (state == ST_HOLD);
    assign out_en = locked || out_unl || ((state == ST_SETTLE) && skip_q);

endmodule

// File: rtl/ref_loss_supervisor_chk.sv
module ref_loss_supervisor_chk
    import ref_sup_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         out_unl,
    input logic         locked,
    input logic         out_en,
    input sup_state_e   state,
    input logic         skip_q,
    input meter_flags_t flags
);

    a_r1_reset_unlocked: assert property (@(posedge clk)
        rst |=> (!locked && state == ST_ACQ));

    a_r2_lock_from_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(state) == ST_SETTLE && flags.valid));

    a_r3_locked_drives_out: assert property (@(posedge clk) disable iff (rst)
        locked |-> out_en);

    a_r4_hold_keeps_lock: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !flags.pulse && !flags.stale) |=> locked);

    a_r6_glitch_unlocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && flags.pulse && !flags.match) |=> !locked);

    a_r10_skip_keeps_out: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE && skip_q) |-> out_en);

    a_r5_unlocked_gate: assert property (@(posedge clk) disable iff (rst)
        (!locked && !out_unl && !out_en) |-> !skip_q || state != ST_SETTLE);

endmodule

bind ref_loss_supervisor ref_loss_supervisor_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .out_unl(out_unl),
    .locked (locked),
    .out_en (out_en),
    .state  (state),
    .skip_q (skip_q),
    .flags  (flags)
);

// File: tb/ref_loss_supervisor_bench.sv
module ref_loss_supervisor_bench;

    localparam int TIMEOUT_CYC = 300;
    localparam int TCS_CYC     = 80;
    localparam int LOCK_CYC    = 40;
    localparam int TOL_SHIFT   = 3;
    localparam int BASE_PER    = 16;

    // single altered period after lock at 16 cycles; tolerance is 2 cycles
    localparam int NVEC = 7;
    localparam int VEC_PER  [NVEC] = '{16, 18, 14, 19, 13, 24, 8};
    localparam bit VEC_LOCK [NVEC] = '{1, 1, 1, 0, 0, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic skip_en = 1'b0;
    logic out_unl = 1'b0;
    logic locked;
    logic out_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ref_loss_supervisor #(
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .TCS_CYC    (TCS_CYC),
        .LOCK_CYC   (LOCK_CYC),
        .TOL_SHIFT  (TOL_SHIFT)
    ) u_ref_loss_supervisor (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .skip_en(skip_en),
        .out_unl(out_unl),
        .locked (locked),
        .out_en (out_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ref_period(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = (i < n / 2);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = 1'b0;
        end
    endtask

    task automatic acquire();
        do_reset();
        for (int i = 0; i < 6; i++) ref_period(BASE_PER);
    endtask

    initial begin
        // R1 reset state
        skip_en = 1'b0;
        out_unl = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R1 locked after reset", locked, 1'b0);
        chk("R1 out_en after reset", out_en, 1'b0);
        out_unl = 1'b1;
        @(negedge clk);
        chk("R5 out_en follows out_unl=1", out_en, 1'b1);
        out_unl = 1'b0;

        // R2 acquisition timing
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R2 not locked before settling", locked, 1'b0);
        ref_period(BASE_PER);
        ref_period(BASE_PER);
        chk("R2 locked after settling", locked, 1'b1);
        chk("R3 out_en while locked, out_unl=0", out_en, 1'b1);

        // R6/R7 table of single altered periods
        for (int v = 0; v < NVEC; v++) begin
            acquire();
            ref_period(VEC_PER[v]);
            @(negedge clk);
            ref_in = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(VEC_LOCK[v] ? "R7 within tolerance" : "R6 period change unlock",
                locked, VEC_LOCK[v]);
        end

        // R4/R5/R8 clean stop past timeout
        out_unl = 1'b0;
        acquire();
        idle(260);
        chk("R4 lock held during gap", locked, 1'b1);
        chk("R4 output held during gap", out_en, 1'b1);
        idle(40);
        chk("R4 unlock after timeout", locked, 1'b0);
        chk("R5 output gated when unlocked", out_en, 1'b0);
        out_unl = 1'b1;
        @(negedge clk);
        chk("R5 output runs when unlocked, out_unl=1", out_en, 1'b1);
        out_unl = 1'b0;
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R8 still unlocked after return", locked, 1'b0);
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R8 relocked after full acquisition", locked, 1'b1);

        // R10 short gap with skip enabled
        skip_en = 1'b1;
        acquire();
        idle(40);
        chk("R4 hold during short gap", locked, 1'b1);
        ref_period(BASE_PER);
        chk("R10 unlocked during reacquire", locked, 1'b0);
        chk("R10 output kept with skip", out_en, 1'b1);
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R10 relocked", locked, 1'b1);

        // R11 short gap with skip disabled
        skip_en = 1'b0;
        acquire();
        idle(40);
        ref_period(BASE_PER);
        chk("R11 unlocked during reacquire", locked, 1'b0);
        chk("R11 output gated without skip", out_en, 1'b0);
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R11 relocked", locked, 1'b1);

        // R9 mid gap: skip has no effect
        skip_en = 1'b1;
        acquire();
        idle(110);
        chk("R9 lock held through mid gap", locked, 1'b1);
        ref_period(BASE_PER);
        chk("R9 unlocked during reacquire", locked, 1'b0);
        chk("R9 skip ignored, output gated", out_en, 1'b0);
        out_unl = 1'b1;
        @(negedge clk);
        chk("R9 output follows out_unl=1", out_en, 1'b1);
        out_unl = 1'b0;
        for (int i = 0; i < 3; i++) ref_period(BASE_PER);
        chk("R9 relocked", locked, 1'b1);

        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 100000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished at cycle %0d", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule